// File: doc/BRIEF.md
# Serial-to-Parallel Word Receiver

This block is the receive shift path of a synchronous serial link. Its clock is the serial bit clock itself. That clock is gated outside the block, so it only toggles while bits are moving. On each rising edge the block samples one bit from the serial data line. It assembles those bits into words of a configurable width, with the earliest bit ending up as the most significant.

When the last bit of a word has been sampled, the finished word appears on the parallel output. A completion strobe goes high for exactly one clock at the same time. Words follow each other with no gap between them: the bit sampled while the strobe is high is already the first bit of the next word. The parallel output keeps the last finished word until the next one replaces it. The surrounding logic can therefore read it at any time between strobes.

The reset is active low and asynchronous, so it clears the block even while the bit clock is stopped.

Top module: `serial_word_receiver`

## Requirements
- R1: While `rst_n` is low, `done_o` is 0, `word_o` is all zeros and the internal bit position is cleared. This holds whether the clock is running or stopped.
- R2: After reset is released, the first strobe comes exactly WIDTH clock edges later. Bits from a word that was cut short by reset never show up in any output word.
- R3: The bit sampled first in a word lands in bit WIDTH-1 of `word_o`, and the bit sampled last lands in bit 0. For WIDTH=8, sampling 1,1,1,1,0,0,0,0 yields 0xF0.
- R4: `done_o` is low while the bits of a word are being sampled. It is high for exactly one clock, in the cycle that follows the edge sampling the word's last bit.
- R5: Words need no separator. The bit sampled at the edge that ends the strobe cycle is bit WIDTH-1 of the next word, and strobes recur every WIDTH clock edges.
- R6: While `done_o` is low, `word_o` keeps the value of the last completed word. It never shows a partly assembled word.
- R7: While the clock is stopped, all state is frozen. Bits presented on `bit_in` during that time have no effect.
- R8: The word width is the parameter WIDTH, which must be at least 2. The default is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gated serial bit clock; bits are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| word_o | output | WIDTH | Last completed word, first received bit in the MSB |
| done_o | output | 1 | One-clock completion strobe, high when `word_o` has just been updated |

## Verification
A bit position counter holding the wrong value shows up at the ports as a strobe at the wrong time. Because strobe spacing is checked on every word, this appears within at most WIDTH clock edges. A corrupted bit history does not disturb the strobe. It only becomes visible in the value captured at the next strobe, which is at most WIDTH edges later, and the scoreboard compares that value against the word the driver sent. A fault in the output register shows up in the very next cycle, because the output is checked to stay unchanged on every non-strobe cycle.

// File: rtl/rx_pkg.sv
`timescale 1ns/1ps
package rx_pkg;
    localparam int DEFAULT_WIDTH = 8;

    // width of a counter that indexes positions 0..n-1
    function automatic int pos_bits(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rx_bit_counter.sv
`timescale 1ns/1ps
module rx_bit_counter #(
    parameter int WIDTH = rx_pkg::DEFAULT_WIDTH
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_o
);
    localparam int CW = rx_pkg::pos_bits(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic [CW-1:0] pos;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pos == LAST) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = (st_q.pos == LAST);
endmodule

// File: rtl/rx_shift_hist.sv
`timescale 1ns/1ps
module rx_shift_hist #(
    parameter int WIDTH = rx_pkg::DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [WIDTH-1:0] next_word_o
);
    localparam int HW = WIDTH - 1;

    typedef struct packed {
        logic [HW-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.hist = HW'({st_q.hist, bit_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // the word as it would stand if the current bit were the last one
    assign next_word_o = {st_q.hist, bit_i};
endmodule

// File: rtl/rx_word_capture.sv
`timescale 1ns/1ps
module rx_word_capture #(
    parameter int WIDTH = rx_pkg::DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] next_word_i,
    output logic [WIDTH-1:0] word_o,
    output logic             done_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             done;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.done = load_i;
        if (load_i) begin
            st_d.word = next_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign done_o = st_q.done;
endmodule

// File: rtl/serial_word_receiver.sv
`timescale 1ns/1ps
module serial_word_receiver #(
    parameter int WIDTH = rx_pkg::DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word_o,
    output logic             done_o
);
    logic             at_last;
    logic [WIDTH-1:0] assembled;

    rx_bit_counter #(.WIDTH(WIDTH)) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_o (at_last)
    );

    rx_shift_hist #(.WIDTH(WIDTH)) i_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_i       (bit_in),
        .next_word_o (assembled)
    );

    rx_word_capture #(.WIDTH(WIDTH)) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (at_last),
        .next_word_i (assembled),
        .word_o      (word_o),
        .done_o      (done_o)
    );
endmodule

// File: rtl/rx_word_checker.sv
`timescale 1ns/1ps
module rx_word_checker #(
    parameter int WIDTH = rx_pkg::DEFAULT_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_in,
    input logic [WIDTH-1:0] word,
    input logic             done
);
    localparam int CW = rx_pkg::pos_bits(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    // independent edge counter modulo WIDTH since reset
    logic [CW-1:0] edge_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            seen_q <= 1'b0;
        end else begin
            edge_q <= (edge_q == LAST) ? '0 : edge_q + 1'b1;
            seen_q <= seen_q | (edge_q == LAST);
        end
    end

    initial begin
        assert (WIDTH >= 2) else $error("R8: WIDTH must be at least 2");
    end

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(word));

    p_last_bit_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word[0] == $past(bit_in)));

    p_order_bit1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word[1] == $past(bit_in, 2)));

    p_strobe_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen_q && edge_q == '0));

    p_boundary_has_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && edge_q == '0) |-> done);
endmodule

bind serial_word_receiver rx_word_checker #(.WIDTH(WIDTH)) i_rx_word_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (bit_in),
    .word   (word_o),
    .done   (done_o)
);

// File: tb/test_serial_word_receiver.sv
`timescale 1ns/1ps
module test_serial_word_receiver;
    localparam int W = 8;

    logic         sys_clk = 1'b0;
    logic         gate    = 1'b0;
    logic         rst_n   = 1'b0;
    logic         bit_in  = 1'b0;
    logic         bit_clk;
    logic [W-1:0] word_o;
    logic         done_o;

    int           checks = 0;
    int           fails  = 0;
    bit           finished = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_word = '0;
    int           since = 0;

    always #10 sys_clk = ~sys_clk;  // 50 MHz
    assign bit_clk = sys_clk & gate;

    serial_word_receiver #(.WIDTH(W)) i_serial_word_receiver (
        .clk    (bit_clk),
        .rst_n  (rst_n),
        .bit_in (bit_in),
        .word_o (word_o),
        .done_o (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: one negedge of the gated clock per bit cycle
    always @(negedge bit_clk) begin
        if (!rst_n) begin
            check(done_o == 1'b0, "R1", "strobe in reset", int'(done_o), 0);
            check(word_o == '0, "R1", "word in reset", int'(word_o), 0);
            since = 0;
            last_word = '0;
        end else begin
            since++;
            if (done_o) begin
                check(since == W, "R5", "cycles between strobes", since, W);
                since = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "strobe with no word pending", 1, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(word_o == e, "R3", "completed word", int'(word_o), int'(e));
                end
                last_word = word_o;
            end else begin
                check(word_o == last_word, "R6", "word held between strobes",
                      int'(word_o), int'(last_word));
                check(since < W, "R4", "strobe missing after last bit", since, W - 1);
            end
        end
    end

    task automatic tick(input logic b);
        @(negedge sys_clk);
        bit_in = b;
        gate = 1'b1;
    endtask

    task automatic stall(input int n);
        logic [W-1:0] w0;
        logic         d0;
        @(negedge sys_clk);
        gate = 1'b0;
        w0 = word_o;
        d0 = done_o;
        for (int k = 0; k < n; k++) begin
            @(negedge sys_clk);
            bit_in = ~bit_in;
        end
        check(word_o == w0, "R7", "word frozen while clock stopped", int'(word_o), int'(w0));
        check(done_o == d0, "R7", "strobe frozen while clock stopped", int'(done_o), int'(d0));
    endtask

    task automatic send_word(input logic [W-1:0] v, input int stall_at, input int stall_len);
        exp_q.push_back(v);
        for (int i = W - 1; i >= 0; i--) begin
            if (W - 1 - i == stall_at) stall(stall_len);
            tick(v[i]);
        end
    endtask

    task automatic do_reset(input int running_cycles);
        @(negedge sys_clk);
        gate = 1'b0;
        @(negedge sys_clk);
        rst_n = 1'b0;
        #1;
        check(done_o == 1'b0, "R1", "strobe cleared at once", int'(done_o), 0);
        check(word_o == '0, "R1", "word cleared at once", int'(word_o), 0);
        @(negedge sys_clk);
        gate = 1'b1;
        for (int k = 0; k < running_cycles; k++) begin
            @(negedge sys_clk);
            bit_in = ~bit_in;
        end
        @(negedge sys_clk);
        gate = 1'b0;
        @(negedge sys_clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset with the clock stopped and then running
        repeat (3) @(negedge sys_clk);
        check(done_o == 1'b0, "R1", "initial strobe", int'(done_o), 0);
        check(word_o == '0, "R1", "initial word", int'(word_o), 0);
        do_reset(4);

        // R3: 1,1,1,1,0,0,0,0 gives 0xF0; R5: further words back to back
        send_word(8'hF0, -1, 0);
        send_word(8'h0F, -1, 0);
        send_word(8'hA5, -1, 0);
        send_word(8'h3C, -1, 0);
        send_word(8'hFF, -1, 0);
        send_word(8'h00, -1, 0);
        send_word(8'h81, -1, 0);

        // R7: stop the clock inside a word and right after a strobe cycle
        send_word(8'h6B, 3, 5);
        send_word(8'hD2, 0, 1);
        tick(1'b1);          // first bit of next word while strobe is high
        stall(4);
        exp_q.push_back(8'hC4);
        for (int i = W - 2; i >= 0; i--) tick(W'(8'hC4) >> i);

        // R2: partial word cut by reset is discarded
        tick(1'b1); tick(1'b0); tick(1'b1);
        do_reset(3);
        send_word(8'h5A, -1, 0);
        send_word(8'h01, -1, 0);

        // long stream of varied words
        for (int n = 0; n < 120; n++) begin
            send_word(W'(n * 37 + 11), (n % 7 == 0) ? (n % W) : -1, 2);
        end

        tick(1'b0);          // let the last strobe be seen
        @(negedge sys_clk);
        gate = 1'b0;
        repeat (2) @(negedge sys_clk);
        check(exp_q.size() == 0, "R4", "words left without strobe", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule